// File: doc/BRIEF.md
# DMA Descriptor Condition Evaluator

This block settles three per-descriptor decisions for a descriptor-driven DMA channel sequencer: whether to raise an interrupt, whether to hold in a wait state, and whether to take the branch or move on to the next sequential descriptor. The sequencer presents the 16-bit command word of the current descriptor together with an `eval_i` strobe. Each decision has its own 2-bit mode field in that word and its own 32-bit select register. Each select register compares a masked group of device-status bits against a reference value.

The decisions are combinational and are valid in the same cycle as the strobe, so the sequencer can act on them at once. A wait that resolves active blocks the other two outcomes for that evaluation, because the descriptor is not retired. An interrupt decision produces a one-cycle request pulse. That pulse sets a sticky interrupt line, which stays high until the clear input is asserted.

Top module: `dma_cond_eval`

## Requirements
- R1: Each select register holds a 4-bit mask in bits 19:16 and a 4-bit reference in bits 3:0. The condition is true when `(status[3:0] & mask) == (ref & mask)`. Every other bit of the select register, and status bits 7:4, has no effect.
- R2: The mode fields sit in the command word with wait in bits 1:0, branch in bits 3:2 and interrupt in bits 5:4. The codes are 00 never, 01 act when the condition is true, 10 act when it is false, and 11 always.
- R3: The three decisions each use their own select register. The same status can therefore give a different outcome for interrupt, branch and wait.
- R4: During `eval_i`, `wait_o` is high exactly when the wait mode resolves to act.
- R5: While `wait_o` is high, `irq_pulse_o`, `branch_o` and `advance_o` are all low.
- R6: During `eval_i` with no wait, exactly one of `branch_o` and `advance_o` is high. `branch_o` is high when the branch mode resolves to act; otherwise `advance_o` is high.
- R7: During `eval_i` with no wait, `irq_pulse_o` is high exactly when the interrupt mode resolves to act.
- R8: `irq_level_o` goes high on the clock edge that ends a cycle with `irq_pulse_o` high. It holds until a cycle with `irq_clr_i` high and no pulse. If a pulse and a clear arrive in the same cycle, the set wins.
- R9: With `eval_i` low, `irq_pulse_o`, `wait_o`, `branch_o` and `advance_o` are all low.
- R10: Synchronous active-low reset leaves `irq_level_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eval_i | input | 1 | Evaluate strobe for the current descriptor |
| cmd_word_i | input | 16 | Descriptor command word holding the three mode fields |
| irq_sel_i | input | 32 | Interrupt select register (mask and reference) |
| br_sel_i | input | 32 | Branch select register (mask and reference) |
| wait_sel_i | input | 32 | Wait select register (mask and reference) |
| dev_status_i | input | 8 | Channel device-status bits; only the low four are compared |
| irq_clr_i | input | 1 | Clears the sticky interrupt line |
| irq_pulse_o | output | 1 | One-cycle interrupt request |
| irq_level_o | output | 1 | Sticky interrupt line |
| wait_o | output | 1 | Hold the descriptor; do not retire it |
| branch_o | output | 1 | Take the branch target |
| advance_o | output | 1 | Advance to the next sequential descriptor |

## Verification
The assertions assume that the command word, the select registers and the status are stable for the whole cycle in which `eval_i` is high. They also assume that `irq_clr_i` is a synchronous level sampled at the clock edge. The stimulus changes every input only on the falling clock edge and holds it through the following rising edge. It drives `irq_clr_i` in isolation, and also together with a pulse, so that the priority between set and clear is covered.

// File: rtl/dma_cond_pkg.sv
// Package: shared mode encoding and decision indexing for the condition evaluator.
// Assumes a 2-bit mode field per decision within the command word.
package dma_cond_pkg;

    localparam int MODE_W = 2;
    localparam int N_DEC  = 3;

    // Decision slots; the index also selects the field position in the command word.
    localparam int DEC_WAIT = 0;
    localparam int DEC_BR   = 1;
    localparam int DEC_IRQ  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_NEVER    = 2'b00,
        MODE_IF_TRUE  = 2'b01,
        MODE_IF_FALSE = 2'b10,
        MODE_ALWAYS   = 2'b11
    } cond_mode_e;

    // Lowest bit of a decision's mode field inside the command word.
    function automatic int field_lsb(input int dec);
        return dec * MODE_W;
    endfunction

endpackage

// File: rtl/dma_cond_match.sv
// Module: masked status comparison for one select register.
// Assumes the mask sits at MASK_LSB and the reference at bit 0, both COND_W wide.
module dma_cond_match #(
    parameter int SEL_W    = 32,
    parameter int STAT_W   = 8,
    parameter int COND_W   = 4,
    parameter int MASK_LSB = 16
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              match_o
);

    logic [COND_W-1:0] mask;
    logic [COND_W-1:0] ref_val;
    logic [COND_W-1:0] stat_low;

    assign mask     = sel_i[MASK_LSB +: COND_W];
    assign ref_val  = sel_i[COND_W-1:0];
    assign stat_low = status_i[COND_W-1:0];

    // Bits outside the mask and reference fields take no part in the decision.
    logic unused_bits;
    assign unused_bits = ^{sel_i[SEL_W-1:MASK_LSB+COND_W],
                           sel_i[MASK_LSB-1:COND_W],
                           status_i[STAT_W-1:COND_W]};

    // Compare the masked status with the masked reference.
    always_comb begin
        match_o = ((stat_low & mask) == (ref_val & mask));
    end

endmodule

// File: rtl/dma_cond_mode.sv
// Module: resolve one decision from its mode code and the condition result.
// Assumes a legal 2-bit code; every code has a defined outcome.
module dma_cond_mode
    import dma_cond_pkg::*;
(
    input  cond_mode_e mode_i,
    input  logic       match_i,
    output logic       act_o
);

    // Map the mode code and condition onto an act/no-act result.
    always_comb begin
        unique case (mode_i)
            MODE_NEVER:    act_o = 1'b0;
            MODE_IF_TRUE:  act_o = match_i;
            MODE_IF_FALSE: act_o = ~match_i;
            MODE_ALWAYS:   act_o = 1'b1;
            default:       act_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_irq_hold.sv
// Module: sticky interrupt flop, set by a request pulse, cleared by a clear input.
// Assumes the set takes priority when both arrive in the same cycle.
module dma_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic level_o
);

    // Hold the line high from a request until it is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_o <= 1'b0;
        else if (set_i)
            level_o <= 1'b1;
        else if (clr_i)
            level_o <= 1'b0;
    end

endmodule

// File: rtl/dma_cond_eval.sv
// Module: top of the condition evaluator. Decodes three mode fields, runs one
// masked compare per decision against shared status, and gates the results so that
// an active wait blocks interrupt and branch. Assumes inputs stable while eval_i is high.
module dma_cond_eval
    import dma_cond_pkg::*;
#(
    parameter int CMD_W    = 16,
    parameter int SEL_W    = 32,
    parameter int STAT_W   = 8,
    parameter int COND_W   = 4,
    parameter int MASK_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [CMD_W-1:0]  cmd_word_i,
    input  logic [SEL_W-1:0]  irq_sel_i,
    input  logic [SEL_W-1:0]  br_sel_i,
    input  logic [SEL_W-1:0]  wait_sel_i,
    input  logic [STAT_W-1:0] dev_status_i,
    input  logic              irq_clr_i,
    output logic              irq_pulse_o,
    output logic              irq_level_o,
    output logic              wait_o,
    output logic              branch_o,
    output logic              advance_o
);

    localparam int FIELDS_W = N_DEC * MODE_W;

    logic [SEL_W-1:0] sel_arr [N_DEC];
    logic [N_DEC-1:0] match;
    logic [N_DEC-1:0] act;

    // Command bits above the mode fields are not decoded here.
    logic unused_cmd;
    assign unused_cmd = ^cmd_word_i[CMD_W-1:FIELDS_W];

    assign sel_arr[DEC_WAIT] = wait_sel_i;
    assign sel_arr[DEC_BR]   = br_sel_i;
    assign sel_arr[DEC_IRQ]  = irq_sel_i;

    // One compare and one mode resolver per decision.
    for (genvar d = 0; d < N_DEC; d++) begin : g_dec
        dma_cond_match #(
            .SEL_W    (SEL_W),
            .STAT_W   (STAT_W),
            .COND_W   (COND_W),
            .MASK_LSB (MASK_LSB)
        ) u_match (
            .sel_i    (sel_arr[d]),
            .status_i (dev_status_i),
            .match_o  (match[d])
        );

        dma_cond_mode u_mode (
            .mode_i  (cond_mode_e'(cmd_word_i[field_lsb(d) +: MODE_W])),
            .match_i (match[d]),
            .act_o   (act[d])
        );
    end

    logic go;

    // Gate the decisions with the strobe; a taken wait blocks retirement.
    always_comb begin
        wait_o      = eval_i & act[DEC_WAIT];
        go          = eval_i & ~act[DEC_WAIT];
        irq_pulse_o = go & act[DEC_IRQ];
        branch_o    = go & act[DEC_BR];
        advance_o   = go & ~act[DEC_BR];
    end

    dma_irq_hold u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (irq_pulse_o),
        .clr_i   (irq_clr_i),
        .level_o (irq_level_o)
    );

endmodule

// File: rtl/dma_cond_eval_chk.sv
// Module: assertion checker for dma_cond_eval, attached through bind.
// Assumes the bound instance uses the default command width.
module dma_cond_eval_chk #(
    parameter int CMD_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eval_i,
    input logic [CMD_W-1:0] cmd_word_i,
    input logic             irq_clr_i,
    input logic             irq_pulse_o,
    input logic             irq_level_o,
    input logic             wait_o,
    input logic             branch_o,
    input logic             advance_o
);

    logic unused_cmd;
    assign unused_cmd = ^{cmd_word_i[CMD_W-1:6], cmd_word_i[3:2]};

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |-> !(irq_pulse_o || wait_o || branch_o || advance_o));

    p_wait_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (!irq_pulse_o && !branch_o && !advance_o));

    p_one_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !wait_o) |-> (branch_o != advance_o));

    p_wait_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && cmd_word_i[1:0] == 2'b11) |-> wait_o);

    p_irq_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && cmd_word_i[5:4] == 2'b00) |-> !irq_pulse_o);

    p_irq_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !wait_o && cmd_word_i[5:4] == 2'b11) |-> irq_pulse_o);

    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |=> irq_level_o);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o && !irq_clr_i) |=> irq_level_o);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !irq_pulse_o) |=> !irq_level_o);

    p_irq_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_level_o && !irq_pulse_o) |=> !irq_level_o);

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !irq_level_o);

endmodule

bind dma_cond_eval dma_cond_eval_chk u_chk (.*);

// File: tb/dma_cond_eval_bench.sv
// Scoreboard bench: the driver pushes expected outcomes; a monitor pops and compares.
module dma_cond_eval_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_i = 1'b0;
    logic [15:0] cmd_word_i = '0;
    logic [31:0] irq_sel_i = '0;
    logic [31:0] br_sel_i = '0;
    logic [31:0] wait_sel_i = '0;
    logic [7:0]  dev_status_i = '0;
    logic        irq_clr_i = 1'b0;
    logic        irq_pulse_o, irq_level_o, wait_o, branch_o, advance_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic  irq;
        logic  wt;
        logic  br;
        logic  adv;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    dma_cond_eval u_dma_cond_eval (
        .clk (clk), .rst_n (rst_n), .eval_i (eval_i), .cmd_word_i (cmd_word_i),
        .irq_sel_i (irq_sel_i), .br_sel_i (br_sel_i), .wait_sel_i (wait_sel_i),
        .dev_status_i (dev_status_i), .irq_clr_i (irq_clr_i),
        .irq_pulse_o (irq_pulse_o), .irq_level_o (irq_level_o), .wait_o (wait_o),
        .branch_o (branch_o), .advance_o (advance_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // R1 model: a status bit matters only where the mask bit is set.
    function automatic logic cond_of(input logic [31:0] sel, input logic [7:0] st);
        return (((st[3:0] ^ sel[3:0]) & sel[19:16]) == 4'h0);
    endfunction

    // R2 model: 00 never, 01 if true, 10 if false, 11 always.
    function automatic logic resolve(input logic [1:0] m, input logic c);
        if (m == 2'b11) return 1'b1;
        if (m == 2'b01) return c;
        if (m == 2'b10) return !c;
        return 1'b0;
    endfunction

    task automatic drive_eval(input logic [15:0] cmd, input logic [31:0] isel,
                              input logic [31:0] bsel, input logic [31:0] wsel,
                              input logic [7:0] st, input string tag);
        exp_t e;
        logic w;
        @(negedge clk);
        cmd_word_i = cmd; irq_sel_i = isel; br_sel_i = bsel; wait_sel_i = wsel;
        dev_status_i = st; eval_i = 1'b1;
        w     = resolve(cmd[1:0], cond_of(wsel, st));
        e.wt  = w;
        e.irq = !w && resolve(cmd[5:4], cond_of(isel, st));
        e.br  = !w && resolve(cmd[3:2], cond_of(bsel, st));
        e.adv = !w && !resolve(cmd[3:2], cond_of(bsel, st));
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare the combinational outcome just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (eval_i && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " R4"}, "wait_o", wait_o, e.wt);
                check({e.tag, " R7"}, "irq_pulse_o", irq_pulse_o, e.irq);
                check({e.tag, " R6"}, "branch_o", branch_o, e.br);
                check({e.tag, " R6"}, "advance_o", advance_o, e.adv);
            end
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0]  st;
        logic [31:0] s0, s1, s2;
        repeat (3) @(negedge clk);
        // R10: reset state.
        check("R10", "irq_level_o after reset", irq_level_o, 1'b0);
        rst_n = 1'b1;

        // R9: all modes always, but no strobe.
        @(negedge clk);
        cmd_word_i = 16'h003F; eval_i = 1'b0;
        @(negedge clk);
        check("R9", "irq_pulse_o idle", irq_pulse_o, 1'b0);
        check("R9", "wait_o idle", wait_o, 1'b0);
        check("R9", "branch_o idle", branch_o, 1'b0);
        check("R9", "advance_o idle", advance_o, 1'b0);
        check("R9", "irq_level_o idle", irq_level_o, 1'b0);

        // R1 R2 R5: every mode combination over varied selects and status.
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 64; m++) begin
                st = 8'(p * 8'h5B + m * 8'h13);
                s0 = 32'hA5A0_5A50 | {12'h0, 4'(p + 9), 12'h0, 4'(m)};
                s1 = 32'h5A50_A5A0 | {12'h0, 4'(m ^ 5), 12'h0, 4'(p)};
                s2 = 32'hFFF0_FFF0 & ~{12'h0, 4'(p * 3), 12'h0, 4'(m >> 2)};
                drive_eval({10'h3A5, 6'(m)}, s0, s1, s2, st, "R1 R2 R5");
            end
        end

        // R3: same status, interrupt matches, branch and wait do not.
        drive_eval(16'h0015, 32'h000F_000A, 32'h000F_0003, 32'h000F_0005, 8'h0A, "R3");
        // R3: the opposite split with if-false modes.
        drive_eval(16'h002A, 32'h000F_0003, 32'h000F_000A, 32'h000F_0005, 8'hFA, "R3");
        // R1: zero mask means the condition is always true.
        drive_eval(16'h0015, 32'hFFF0_FFF7, 32'h0000_0009, 32'h0000_0000, 8'hF6, "R1");

        @(negedge clk);
        eval_i = 1'b0;
        wait (sb_q.size() == 0);

        // R8: clear, set, hold, clear, then set against clear.
        @(negedge clk); irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
        check("R8", "irq_level_o after clear", irq_level_o, 1'b0);
        cmd_word_i = 16'h0030; eval_i = 1'b1;
        @(negedge clk); eval_i = 1'b0;
        check("R8", "irq_level_o after pulse", irq_level_o, 1'b1);
        repeat (3) @(negedge clk);
        check("R8", "irq_level_o held", irq_level_o, 1'b1);
        irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
        check("R8", "irq_level_o cleared", irq_level_o, 1'b0);
        eval_i = 1'b1; irq_clr_i = 1'b1;
        @(negedge clk); eval_i = 1'b0; irq_clr_i = 1'b0;
        check("R8", "irq_level_o set wins", irq_level_o, 1'b1);
        // R5: a taken wait raises no interrupt.
        irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
        cmd_word_i = 16'h0033; eval_i = 1'b1;
        @(negedge clk); eval_i = 1'b0;
        check("R5", "irq_level_o after waiting eval", irq_level_o, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule